// File: doc/BRIEF.md
# Iterative Binary-GCD Divider over GF(2^m)

This block divides one element of a binary extension field by another. The field uses a polynomial basis. Given operands `a`, `b` and an irreducible modulus `g` of degree m, it returns `p = a / b mod g`. When `a` is the constant 1, the result is the inverse of `b`. The block serves as the slow, area-lean division unit in an elliptic-curve datapath. The caller presents the three operands with a one-cycle `start` pulse, waits for `done`, and then reads `p`.

Internally, four state registers run a binary extended GCD. S starts as the modulus, R starts as the divisor, U starts as the dividend and V starts as zero. In each clock the block does one of two things:

- **Halving cycle.** If either R or S is even, each even one is divided by x. At the same time, its partner (U or V) is divided by x modulo g. The two pairs are handled independently, in the same cycle.
- **Combine cycle.** If R and S are both odd, the larger of them is replaced by their XOR sum. Its partner is replaced by U xor V.

When S reaches zero, U holds the quotient. The block finishes with m = 163 as the default width. The intended default modulus is x^163+x^7+x^6+x^3+1. Any modulus of degree at most m works, so smaller fields can run on the same hardware.

Top module: `gf2m_gcd_div`

## Requirements
- R1: After reset, `busy`, `done` and `p` are all zero.
- R2: A `start` sampled while idle loads the operands, and `busy` is high from the next cycle. A `start` that arrives while `busy` is high has no effect on the running operation or its result.
- R3: In a cycle where R is even, R is shifted right by one and U becomes (U xor u0·g)/x. In the same cycle, if S is even, S and V are treated the same way. Both pairs update in that one clock.
- R4: In a cycle where R and S are both odd, the following happens. If S ≥ R as unsigned integers, S takes S xor R and V takes U xor V. Otherwise R takes S xor R and U takes U xor V. Either way, the updated register is even afterwards.
- R5: When the operation ends, p·b mod g equals a for every nonzero b.
- R6: `done` is high for exactly one cycle, and in that same cycle `busy` falls.
- R7: `p` changes only at completion, and it holds its value until the next completion.
- R8: At most 3m clock cycles of halving or combining pass between load and completion.
- R9: The modulus captured at load does not change while `busy` is high.
- R10: Small-field results are as follows.
  - Over g = x^4+x+1 (0x13), a = 0xE and b = 0xB give 0x3.
  - Over g = x^8+x^4+x^3+x^2+1 (0x11D), a = 0x2B and b = 0x4E give 0x95.
  - Over g = 0x13, a = 1 and b = 2 give 0x9.
  - a = 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load pulse, honoured only while idle |
| a | input | M | Dividend |
| b | input | M | Divisor, must be nonzero |
| g | input | M+1 | Irreducible modulus, degree at most M |
| p | output | M | Quotient, held between operations |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions are checked on every cycle. They cover four things:

- the shift applied to an even R,
- the evenness that each combine leaves behind,
- the fixed modulus and the single-cycle `done`,
- the stability of `p` and the 3m cycle bound.

Whether the quotient is arithmetically right can only be shown by the bench scenarios. These are the small-field vectors, random 163-bit operands checked by multiplying back, and a start pulse injected during a running division.

// File: rtl/gf2m_gcd_div.sv
module gf2m_gcd_div #(
  parameter int M = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  input  logic [M:0]   g,
  output logic [M-1:0] p,
  output logic         busy,
  output logic         done
);
  localparam int LIM = 3 * M;
  localparam int CW  = $clog2(LIM + 2);

  logic [M:0]   sq;
  logic [M-1:0] rq, uq, vq, gh;
  logic [CW-1:0] cyc;

  wire          finish = (sq == '0);
  wire          r_even = ~rq[0];
  wire          s_even = ~sq[0];
  wire          halve  = r_even | s_even;
  wire [M-1:0]  u_half = (uq >> 1) ^ (uq[0] ? gh : '0);
  wire [M-1:0]  v_half = (vq >> 1) ^ (vq[0] ? gh : '0);
  wire [M:0]    sum_sr = sq ^ {1'b0, rq};
  wire [M-1:0]  sum_uv = uq ^ vq;
  wire          s_ge_r = (sq >= {1'b0, rq});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= '0; rq <= '0; uq <= '0; vq <= '0; gh <= '0;
      p <= '0; busy <= 1'b0; done <= 1'b0; cyc <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sq <= g; rq <= b; uq <= a; vq <= '0; gh <= g[M:1];
          busy <= 1'b1; cyc <= '0;
        end
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        p    <= uq;
      end else begin
        cyc <= cyc + 1'b1;
        if (halve) begin
          if (r_even) begin rq <= rq >> 1; uq <= u_half; end
          if (s_even) begin sq <= sq >> 1; vq <= v_half; end
        end else if (s_ge_r) begin
          sq <= sum_sr; vq <= sum_uv;
        end else begin
          rq <= sum_sr[M-1:0]; uq <= sum_uv;
        end
      end
    end
  end

  // R3
  r_halve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish && r_even |=> rq == ($past(rq) >> 1));

  // R4
  comb_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish && !halve |=> (!rq[0] || !sq[0]));

  // R9
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(gh));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  // R7
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(p));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish && start |=> busy);

  // R8
  lat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cyc <= CW'(LIM));
endmodule

// File: tb/sim_gf2m_gcd_div.sv
module sim_gf2m_gcd_div;
  localparam int M = 163;
  localparam int NV = 5;
  localparam logic [M:0] G163 = (164'd1 << 163) | 164'hC9;

  localparam logic [M:0]   TG [NV] = '{164'h13, 164'h11D, 164'h13, G163, G163};
  localparam logic [M-1:0] TA [NV] = '{163'hE, 163'h2B, 163'h1, 163'h1234567, 163'h0};
  localparam logic [M-1:0] TB [NV] = '{163'hB, 163'h4E, 163'h2, 163'h1234567, 163'h5};
  localparam logic [M-1:0] TE [NV] = '{163'h3, 163'h95, 163'h9, 163'h1, 163'h0};
  localparam int           TD [NV] = '{4, 8, 4, 163, 163};

  logic clk = 0, rst_n = 0, start = 0;
  logic [M-1:0] a = '0, b = '0, p;
  logic [M:0] g = '0;
  logic busy, done;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  gf2m_gcd_div #(.M(M)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .g(g), .p(p), .busy(busy), .done(done));

  function automatic logic [M-1:0] mulmod(logic [M-1:0] x, logic [M-1:0] y, logic [M:0] gg);
    logic [2*M-1:0] acc = '0;
    for (int i = 0; i < M; i++) if (y[i]) acc ^= {{M{1'b0}}, x} << i;
    for (int i = 2*M-2; i >= M; i--) if (acc[i]) acc ^= {{(M-1){1'b0}}, gg} << (i - M);
    return acc[M-1:0];
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [M-1:0] r = '0;
    for (int i = 0; i < 6; i++) r = (r << 32) | M'($urandom);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [M:0] gg, input logic [M-1:0] aa, input logic [M-1:0] bb, output int lat);
    @(negedge clk);
    g = gg; a = aa; b = bb; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
  endtask

  initial begin
    #3_000_000;
    nbad++; nchk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int lat;
    logic [M-1:0] pk, ra, rb;
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && p == '0, "R1", p, '0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      run(TG[k], TA[k], TB[k], lat);
      // R10 / R5
      check(done && p == TE[k], "R10", p, TE[k]);
      // R8
      check(lat <= 3*TD[k] + 2, "R8", M'(lat), M'(3*TD[k] + 2));
      // R6
      check(!busy, "R6", M'(busy), '0);
    end

    for (int k = 0; k < 20; k++) begin
      ra = rnd(); rb = rnd();
      if (rb == '0) rb = 1;
      run(G163, ra, rb, lat);
      // R5
      check(mulmod(p, rb, G163) == ra, "R5", mulmod(p, rb, G163), ra);
      // R8
      check(lat <= 3*M + 2, "R8", M'(lat), M'(3*M + 2));
    end

    pk = p;
    @(negedge clk);
    // R6
    check(!done, "R6", M'(done), '0);
    repeat (10) @(negedge clk);
    // R7
    check(p == pk, "R7", p, pk);

    ra = rnd(); rb = rnd() | 1;
    @(negedge clk);
    g = G163; a = ra; b = rb; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    a = rnd(); b = rnd() | 2; start = 1;
    @(negedge clk);
    start = 0;
    // R2
    check(busy, "R2", M'(busy), 1);
    lat = 0;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    // R2
    check(mulmod(p, rb, G163) == ra, "R2", mulmod(p, rb, G163), ra);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule